// File: doc/BRIEF.md
# Switchable QPSK/DQPSK Baseband Modem

This block is a baseband modem loopback with two branches behind one interface. The upper branch maps coded bit pairs onto absolute QPSK constellation points. The lower branch maps them onto DQPSK phase steps. Each branch feeds its own modulator output straight into its own hard-decision demodulator. A one-bit select input picks which branch is live. The other branch is held in its cleared state, and only the live branch drives the outputs.

Input symbols come from a rate-1/2 convolutional coder, so each input is one dibit. The modulator output is a pair of signed fixed-point samples scaled by 1000, so a level of 0.707 appears as ±707. All state advances only on cycles where the clock enable is high. A synchronous reset overrides the enable.

The control sequencer has four states: `ST_LO_START`, `ST_LO_RUN`, `ST_UP_START` and `ST_UP_RUN`. It moves only on enabled cycles. Its transitions are:
- Reset enters `ST_LO_START`.
- `ST_LO_START` goes to `ST_LO_RUN` when select is 0, or to `ST_UP_START` when select is 1.
- `ST_LO_RUN` stays while select is 0 and goes to `ST_UP_START` when select is 1.
- `ST_UP_START` goes to `ST_UP_RUN` when select is 1, or to `ST_LO_START` when select is 0.
- `ST_UP_RUN` stays while select is 1 and goes to `ST_LO_START` when select is 0.

Top module: `qpsk_dqpsk_modem`

## Requirements
- R1: After reset, `tx_valid` and `rx_valid` are 0 and the sequencer is in `ST_LO_START`.
- R2: Select 1 routes traffic through the QPSK branch and select 0 through the DQPSK branch. Outputs come only from the branch whose run state is active.
- R3: Every valid modulator sample has I and Q each equal to +707 or -707, as 12-bit two's complement values.
- R4: QPSK mapping, written `{in_dibit[1],in_dibit[0]}` → (I,Q), is: 00→(+707,+707), 01→(-707,+707), 11→(-707,-707), 10→(+707,-707).
- R5: DQPSK adds a phase step to the previous symbol: 00→0°, 01→+90°, 11→180°, 10→-90°. Phase 45° is (+,+), 135° is (-,+), 225° is (-,-) and 315° is (+,-). The reference phase is 45° after reset and whenever the branch restarts.
- R6: An accepted dibit appears on `tx_i`/`tx_q` with `tx_valid` after one enabled cycle. It comes back on `rx_dibit` with `rx_valid` after two enabled cycles. QPSK uses the signs of I and Q; DQPSK uses the quadrant difference from the previous symbol.
- R7: On a select change, the following happen:
  - An input on the edge where select first differs from the running branch is dropped.
  - The sequencer spends one enabled cycle in the new branch's start state, and inputs are ignored there.
  - Symbols still in flight in the old branch are discarded.
  - The new branch starts from its reset state, and its outputs are not valid until its first symbol completes.
- R8: While `ce` is 0, no input is accepted and all outputs hold their values.
- R9: On an enabled cycle with `in_valid` 0, no symbol is produced: `tx_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable |
| sel | input | 1 | 1 = QPSK branch, 0 = DQPSK branch |
| in_valid | input | 1 | Input dibit is present |
| in_dibit | input | 2 | Coded bit pair |
| tx_i | output | 12 | Modulator in-phase sample (signed), 0 when not valid |
| tx_q | output | 12 | Modulator quadrature sample (signed), 0 when not valid |
| tx_valid | output | 1 | Modulator sample valid |
| rx_dibit | output | 2 | Recovered bit pair |
| rx_valid | output | 1 | Recovered bit pair valid |

## Verification
Two things can happen on the same edge: a branch switch and symbol traffic. That traffic is either a dibit still inside the old branch's pipeline or a new dibit offered as select flips. The bench provokes this case directly:
- It sends a QPSK symbol.
- On the very next edge it flips select while offering another dibit.
- On the start-state edge that follows, it offers a third dibit.

The scoreboard expects the first symbol's modulator sample and nothing else. Any `rx_valid` or `tx_valid` before the next DQPSK symbol counts as a failure. That next DQPSK symbol must also show the 45° reference restored.

// File: rtl/modem_pkg.sv
package modem_pkg;

    typedef enum logic [1:0] {
        ST_LO_START = 2'd0,
        ST_LO_RUN   = 2'd1,
        ST_UP_START = 2'd2,
        ST_UP_RUN   = 2'd3
    } mode_e;

    // Gray position around the circle: 00,01,11,10 -> 0,1,2,3
    function automatic logic [1:0] dibit_to_idx(input logic [1:0] d);
        logic [1:0] r;
        unique case (d)
            2'b00: r = 2'd0;
            2'b01: r = 2'd1;
            2'b11: r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] idx_to_dibit(input logic [1:0] k);
        logic [1:0] r;
        unique case (k)
            2'd0: r = 2'b00;
            2'd1: r = 2'b01;
            2'd2: r = 2'b11;
            default: r = 2'b10;
        endcase
        return r;
    endfunction

    // quadrant index 0..3 = 45,135,225,315 degrees
    function automatic logic idx_neg_i(input logic [1:0] k);
        return (k == 2'd1) || (k == 2'd2);
    endfunction

    function automatic logic idx_neg_q(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import modem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ce,
    input  logic  sel,
    output mode_e state,
    output logic  up_run,
    output logic  lo_run
);

    mode_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst)     st_q <= ST_LO_START;
        else if (ce) st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LO_START: st_d = sel ? ST_UP_START : ST_LO_RUN;
            ST_LO_RUN:   st_d = sel ? ST_UP_START : ST_LO_RUN;
            ST_UP_START: st_d = sel ? ST_UP_RUN   : ST_LO_START;
            ST_UP_RUN:   st_d = sel ? ST_UP_RUN   : ST_LO_START;
        endcase
    end

    always_comb begin
        state  = st_q;
        up_run = 1'b0;
        lo_run = 1'b0;
        unique case (st_q)
            ST_UP_RUN:   up_run = 1'b1;
            ST_LO_RUN:   lo_run = 1'b1;
            ST_LO_START,
            ST_UP_START: ;
        endcase
    end

    // R7: leaving the upper run state always passes through the lower start state
    p_switch_down_r7: assert property (@(posedge clk) disable iff (rst)
        (ce && st_q == ST_UP_RUN && !sel) |=> (st_q == ST_LO_START));

    // R7: a start state never lasts beyond one enabled cycle
    p_start_brief_r7: assert property (@(posedge clk) disable iff (rst)
        (ce && st_q == ST_LO_START && !sel) |=> (st_q == ST_LO_RUN));

    // R8: no movement without enable
    p_fsm_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(st_q));

endmodule

// File: rtl/modem_branch.sv
module modem_branch
    import modem_pkg::*;
#(
    parameter int AMP_W        = 12,
    parameter int AMP          = 707,
    parameter bit DIFFERENTIAL = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold,
    input  logic                    ce,
    input  logic                    take,
    input  logic [1:0]              dibit,
    output logic signed [AMP_W-1:0] tx_i,
    output logic signed [AMP_W-1:0] tx_q,
    output logic                    tx_v,
    output logic [1:0]              rx_dibit,
    output logic                    rx_v
);

    localparam logic signed [AMP_W-1:0] AMP_P = AMP_W'(AMP);
    localparam logic signed [AMP_W-1:0] AMP_N = -AMP_P;

    logic       clr;
    logic [1:0] tx_idx_q;
    logic [1:0] sym_idx_d;
    logic [1:0] rx_quad;
    logic [1:0] rx_idx;

    assign clr = rst | hold;

    // ---------------- modulator ----------------
    generate
        if (DIFFERENTIAL) begin : g_dmod
            assign sym_idx_d = tx_idx_q + dibit_to_idx(dibit);
        end else begin : g_amod
            assign sym_idx_d = dibit_to_idx(dibit);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            tx_idx_q <= 2'd0;   // 45 degree reference
            tx_v     <= 1'b0;
        end else if (ce) begin
            tx_v <= take;
            if (take) tx_idx_q <= sym_idx_d;
        end
    end

    assign tx_i = idx_neg_i(tx_idx_q) ? AMP_N : AMP_P;
    assign tx_q = idx_neg_q(tx_idx_q) ? AMP_N : AMP_P;

    // ---------------- demodulator ----------------
    assign rx_quad = dibit_to_idx({tx_q[AMP_W-1], tx_i[AMP_W-1]});

    generate
        if (DIFFERENTIAL) begin : g_ddem
            logic [1:0] prev_quad_q;
            always_ff @(posedge clk) begin
                if (clr)              prev_quad_q <= 2'd0;
                else if (ce && tx_v)  prev_quad_q <= rx_quad;
            end
            assign rx_idx = rx_quad - prev_quad_q;
        end else begin : g_adem
            assign rx_idx = rx_quad;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            rx_v     <= 1'b0;
            rx_dibit <= 2'b00;
        end else if (ce) begin
            rx_v <= tx_v;
            if (tx_v) rx_dibit <= idx_to_dibit(rx_idx);
        end
    end

    // R3: valid samples sit exactly on the scaled constellation
    p_amp_r3: assert property (@(posedge clk) disable iff (rst)
        tx_v |-> ((tx_i == AMP_P || tx_i == AMP_N) && (tx_q == AMP_P || tx_q == AMP_N)));

    // R6: a modulated symbol is demodulated on the next enabled edge
    p_lat_r6: assert property (@(posedge clk) disable iff (clr)
        (ce && tx_v) |=> rx_v);

    // R7: a disabled branch carries nothing
    p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!tx_v && !rx_v));

    // R8: frozen while enable is low
    p_freeze_r8: assert property (@(posedge clk) disable iff (clr)
        !ce |=> ($stable(tx_idx_q) && $stable(tx_v) && $stable(rx_v) && $stable(rx_dibit)));

    // R9: no input, no symbol
    p_no_input_r9: assert property (@(posedge clk) disable iff (clr)
        (ce && !take) |=> !tx_v);

endmodule

// File: rtl/qpsk_dqpsk_modem.sv
module qpsk_dqpsk_modem
    import modem_pkg::*;
#(
    parameter int AMP_W = 12,
    parameter int AMP   = 707
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic                    sel,
    input  logic                    in_valid,
    input  logic [1:0]              in_dibit,
    output logic signed [AMP_W-1:0] tx_i,
    output logic signed [AMP_W-1:0] tx_q,
    output logic                    tx_valid,
    output logic [1:0]              rx_dibit,
    output logic                    rx_valid
);

    mode_e state;
    logic  up_run, lo_run;

    logic signed [AMP_W-1:0] up_i, up_q, lo_i, lo_q;
    logic       up_tv, lo_tv, up_rv, lo_rv;
    logic [1:0] up_rd, lo_rd;

    mode_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .sel    (sel),
        .state  (state),
        .up_run (up_run),
        .lo_run (lo_run)
    );

    modem_branch #(.AMP_W(AMP_W), .AMP(AMP), .DIFFERENTIAL(1'b0)) u_upper (
        .clk      (clk),
        .rst      (rst),
        .hold     (!up_run),
        .ce       (ce),
        .take     (in_valid && up_run && sel),
        .dibit    (in_dibit),
        .tx_i     (up_i),
        .tx_q     (up_q),
        .tx_v     (up_tv),
        .rx_dibit (up_rd),
        .rx_v     (up_rv)
    );

    modem_branch #(.AMP_W(AMP_W), .AMP(AMP), .DIFFERENTIAL(1'b1)) u_lower (
        .clk      (clk),
        .rst      (rst),
        .hold     (!lo_run),
        .ce       (ce),
        .take     (in_valid && lo_run && !sel),
        .dibit    (in_dibit),
        .tx_i     (lo_i),
        .tx_q     (lo_q),
        .tx_v     (lo_tv),
        .rx_dibit (lo_rd),
        .rx_v     (lo_rv)
    );

    always_comb begin
        tx_i     = '0;
        tx_q     = '0;
        tx_valid = 1'b0;
        rx_dibit = 2'b00;
        rx_valid = 1'b0;
        unique case (state)
            ST_UP_RUN: begin
                tx_valid = up_tv;
                tx_i     = up_tv ? up_i : '0;
                tx_q     = up_tv ? up_q : '0;
                rx_valid = up_rv;
                rx_dibit = up_rd;
            end
            ST_LO_RUN: begin
                tx_valid = lo_tv;
                tx_i     = lo_tv ? lo_i : '0;
                tx_q     = lo_tv ? lo_q : '0;
                rx_valid = lo_rv;
                rx_dibit = lo_rd;
            end
            ST_LO_START,
            ST_UP_START: ;
        endcase
    end

    // R2: at most one branch is ever live
    p_one_branch_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up_run, lo_run}));

    // R7: a fresh branch produces nothing on its first run cycle
    p_fresh_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (ce && (state == ST_UP_START || state == ST_LO_START)) |=> !rx_valid);

endmodule

// File: tb/qpsk_dqpsk_modem_tb.sv
module qpsk_dqpsk_modem_tb_top;

    logic clk = 1'b0;
    logic rst, ce, sel, in_valid;
    logic [1:0] in_dibit;
    logic signed [11:0] tx_i, tx_q;
    logic tx_valid, rx_valid;
    logic [1:0] rx_dibit;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [1:0] exp_tx[$];
    logic [1:0] exp_rx[$];
    logic [1:0] ph;

    always #2.5 clk = ~clk;   // 200 MHz

    qpsk_dqpsk_modem dut_i (
        .clk(clk), .rst(rst), .ce(ce), .sel(sel),
        .in_valid(in_valid), .in_dibit(in_dibit),
        .tx_i(tx_i), .tx_q(tx_q), .tx_valid(tx_valid),
        .rx_dibit(rx_dibit), .rx_valid(rx_valid)
    );

    function automatic logic [1:0] step_of(input logic [1:0] d);
        case (d)
            2'b00: return 2'd0;
            2'b01: return 2'd1;
            2'b11: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic signed [11:0] exp_i(input logic [1:0] k);
        return (k == 2'd1 || k == 2'd2) ? -12'sd707 : 12'sd707;
    endfunction

    function automatic logic signed [11:0] exp_q(input logic [1:0] k);
        return (k >= 2'd2) ? -12'sd707 : 12'sd707;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // driver: offers one dibit that the bench knows will be accepted
    task automatic send(input logic [1:0] d);
        @(negedge clk);
        ce = 1'b1; in_valid = 1'b1; in_dibit = d;
        if (sel) exp_tx.push_back(step_of(d));           // R4 absolute
        else begin
            ph = ph + step_of(d);                        // R5 differential
            exp_tx.push_back(ph);
        end
        exp_rx.push_back(d);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ce = 1'b1; in_valid = 1'b0;
        end
    endtask

    // monitor: scoreboard compare right after every enabled edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && ce) begin
                if (tx_valid) begin
                    if (exp_tx.size() == 0)
                        chk(1'b0, "R7 unexpected tx_valid", 1, 0);
                    else begin
                        logic [1:0] k;
                        k = exp_tx.pop_front();
                        chk(tx_i == exp_i(k), "R3/R4/R5 tx_i", tx_i, exp_i(k));
                        chk(tx_q == exp_q(k), "R3/R4/R5 tx_q", tx_q, exp_q(k));
                    end
                end
                if (rx_valid) begin
                    if (exp_rx.size() == 0)
                        chk(1'b0, "R7 unexpected rx_valid", 1, 0);
                    else begin
                        logic [1:0] d;
                        d = exp_rx.pop_front();
                        chk(rx_dibit == d, "R6 rx_dibit", rx_dibit, d);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic signed [11:0] held_i;
        rst = 1'b1; ce = 1'b1; sel = 1'b0; in_valid = 1'b0; in_dibit = 2'b00;
        ph = 2'd0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(tx_valid == 1'b0, "R1 tx_valid in reset", tx_valid, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
        rst = 1'b0;
        idle(2);

        // R5 DQPSK from the 45 degree reference, all four steps
        foreach (exp_rx[k]) ;
        send(2'b00); send(2'b01); send(2'b11); send(2'b10);
        send(2'b01); send(2'b01); send(2'b10); send(2'b00); send(2'b11);
        idle(1);
        // R9: idle cycle produced no symbol
        @(negedge clk); chk(tx_valid == 1'b0, "R9 tx_valid after idle", tx_valid, 0);
        idle(3);

        // R2 switch to QPSK: start cycle then run
        @(negedge clk); sel = 1'b1; in_valid = 1'b0;
        idle(2);
        send(2'b00); send(2'b01); send(2'b11); send(2'b10);
        send(2'b11); send(2'b00);
        idle(4);

        // R8 enable low: nothing accepted, outputs held
        send(2'b01);
        @(negedge clk); ce = 1'b0; in_valid = 1'b1; in_dibit = 2'b11;
        held_i = tx_i;
        @(negedge clk);
        @(negedge clk);
        chk(tx_i == held_i, "R8 tx_i held", tx_i, held_i);
        chk(tx_valid == 1'b1, "R8 tx_valid held", tx_valid, 1);
        chk(rx_valid == 1'b0, "R8 rx_valid held", rx_valid, 0);
        ce = 1'b1; in_valid = 1'b0;
        idle(4);
        chk(exp_rx.size() == 0, "R8 nothing extra accepted", exp_rx.size(), 0);

        // R7 switch while a symbol is in flight, inputs on switch and start edges
        @(negedge clk); ce = 1'b1; in_valid = 1'b1; in_dibit = 2'b10;
        exp_tx.push_back(2'd3);                 // modulated, then discarded
        @(negedge clk); sel = 1'b0; in_valid = 1'b1; in_dibit = 2'b01;   // dropped
        @(negedge clk); in_valid = 1'b1; in_dibit = 2'b11;               // start state
        @(negedge clk); in_valid = 1'b0;
        chk(rx_valid == 1'b0, "R7 in-flight rx discarded", rx_valid, 0);
        chk(tx_valid == 1'b0, "R7 no tx during restart", tx_valid, 0);
        idle(3);
        chk(exp_tx.size() == 0, "R7 tx queue drained", exp_tx.size(), 0);

        // R5 restart: reference back at 45 degrees
        ph = 2'd0;
        send(2'b01); send(2'b01); send(2'b01); send(2'b01); send(2'b10);
        idle(5);

        chk(exp_tx.size() == 0, "R6 all tx seen", exp_tx.size(), 0);
        chk(exp_rx.size() == 0, "R6 all rx seen", exp_rx.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule